// File: doc/BRIEF.md
# Top-Down Issue Slot Classifier

This block sorts the issue slots between an instruction frontend and an execution backend, every clock cycle, into top-down bottleneck categories. With an issue width of `SLOTS`, each cycle offers `SLOTS` slots. Every one of them is assigned to exactly one first-level category: retiring, bad speculation, frontend bound or backend bound. Frontend-bound and backend-bound slots are then refined into second-level and third-level sub-states, using stall-cause flags that the pipeline supplies.

The inputs describe one cycle of the frontend/backend handshake. They are the uop count the frontend offers, the uop count the backend can take, whether the decoders hold opcode bytes, a flush pulse, a post-flush recovery flag and the retired count. Seven cause flags cover fetch translation miss, fetch line miss, fetch redirect, data translation miss, data cache miss, page walk and serialization. Every output is a per-cycle slot count from 0 to `SLOTS`, registered once, and is meant to feed a bank of event accumulators.

Top module: `tma_slot_classifier`

## Requirements
- R1: While rst_ni is low, every count output is 0.
- R2: Each output reflects the inputs sampled at the previous rising clock edge. After the first edge out of reset, the four first-level counts sum to SLOTS every cycle.
- R3: Backend-bound slots equal SLOTS minus the clamped backend accept count.
- R4: Empty slots are the clamped accept count minus the issued count, where the issued count is min(offer, accept) after clamping. Empty slots are frontend bound when the recovery flag is low and bad speculation when it is high.
- R5: When the flush pulse is high, every issued uop of that cycle counts as bad speculation and the retiring count is 0.
- R6: When there is no flush, retiring is min(retired count, issued count), and the remaining issued slots count as bad speculation.
- R7: Frontend-bound slots go to the latency count when the decoders hold no opcode bytes and to the bandwidth count when they do. The two sum to the frontend-bound count.
- R8: Latency slots go whole to one third-level state, chosen by priority: fetch translation miss first, then fetch line miss, then redirect. When no flag is set they stay in the latency count only.
- R9: Backend-bound slots count as memory bound when the data translation, data cache or page walk flag is set, and as core bound otherwise. The two sum to the backend-bound count.
- R10: Memory-bound slots go to the address state when the data translation or page walk flag is set. Otherwise they go to the data state when the data cache flag is set. Otherwise they stay in the memory-bound count only.
- R11: Core-bound slots also count as serialization when the serialization flag is set, and serialization is 0 otherwise.
- R12: Offer, accept and retired counts above SLOTS are treated as SLOTS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fe_offer_i | input | CW | Uops offered by the frontend |
| be_accept_i | input | CW | Uops the backend can take |
| dec_bytes_i | input | 1 | Decoders hold opcode bytes |
| flush_i | input | 1 | Pipeline flush this cycle |
| recover_i | input | 1 | Post-flush recovery window |
| retired_i | input | CW | Uops retired from this cycle's issue |
| itlb_miss_i | input | 1 | Fetch translation outstanding |
| icache_miss_i | input | 1 | Fetch line outstanding |
| redirect_i | input | 1 | Fetch redirect after control transfer |
| dtlb_miss_i | input | 1 | Data translation outstanding |
| dcache_miss_i | input | 1 | Load/store data outstanding |
| page_walk_i | input | 1 | Translation missed all TLBs, walking |
| serialize_i | input | 1 | Fence or CSR serialization stall |
| retire_o | output | CW | Retiring slots |
| bad_spec_o | output | CW | Bad speculation slots |
| fe_bound_o | output | CW | Frontend-bound slots |
| be_bound_o | output | CW | Backend-bound slots |
| fe_lat_o | output | CW | Frontend latency slots |
| fe_bw_o | output | CW | Frontend bandwidth slots |
| mem_bound_o | output | CW | Memory-bound slots |
| core_bound_o | output | CW | Core-bound slots |
| fe_addr_o | output | CW | Frontend address latency slots |
| fe_data_o | output | CW | Frontend data latency slots |
| fe_redir_o | output | CW | Frontend redirect latency slots |
| mem_addr_o | output | CW | Memory address slots |
| mem_data_o | output | CW | Memory data slots |
| core_serial_o | output | CW | Serialization slots |

## Verification
Every count passes through exactly one register, so each result is due one rising edge after its stimulus. The bench drives a vector on a falling edge and compares all fourteen counts on the next falling edge, before it drives the following vector. The reset check is taken on a falling edge while rst_ni is still low. The expected counts for each vector come from a bench function built from the requirements. This function also covers clamping of counts above SLOTS and the priority among cause flags.

// File: rtl/tma_pkg.sv
package tma_pkg;
  typedef enum logic [1:0] {FE_NONE, FE_ADDR, FE_DATA, FE_REDIR} fe_cause_e;
  typedef enum logic [1:0] {MEM_NONE, MEM_ADDR, MEM_DATA} mem_cause_e;
endpackage

// File: rtl/tma_l1_split.sv
module tma_l1_split #(
  parameter int SLOTS = 4,
  parameter int CW    = $clog2(SLOTS + 1)
) (
  input  logic [CW-1:0] offer_i,
  input  logic [CW-1:0] accept_i,
  input  logic [CW-1:0] retired_i,
  input  logic          flush_i,
  input  logic          recover_i,
  output logic [CW-1:0] retire_o,
  output logic [CW-1:0] bad_o,
  output logic [CW-1:0] fe_o,
  output logic [CW-1:0] be_o
);
  localparam logic [CW-1:0] NMAX = CW'(SLOTS);

  logic [CW-1:0] off_c, acc_c, ret_c, issued, empty, ret_eff;

  always_comb begin
    off_c   = (offer_i   > NMAX) ? NMAX : offer_i;
    acc_c   = (accept_i  > NMAX) ? NMAX : accept_i;
    ret_c   = (retired_i > NMAX) ? NMAX : retired_i;
    issued  = (off_c < acc_c) ? off_c : acc_c;
    empty   = acc_c - issued;
    ret_eff = (ret_c < issued) ? ret_c : issued;
    retire_o = flush_i ? '0 : ret_eff;
    // unretired issue plus recovery bubbles
    bad_o    = (issued - retire_o) + (recover_i ? empty : '0);
    fe_o     = recover_i ? '0 : empty;
    be_o     = NMAX - acc_c;
  end
endmodule

// File: rtl/tma_fe_tree.sv
module tma_fe_tree
  import tma_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int CW    = $clog2(SLOTS + 1)
) (
  input  logic [CW-1:0] fe_bound_i,
  input  logic          dec_bytes_i,
  input  logic          itlb_miss_i,
  input  logic          icache_miss_i,
  input  logic          redirect_i,
  output logic [CW-1:0] lat_o,
  output logic [CW-1:0] bw_o,
  output logic [CW-1:0] addr_o,
  output logic [CW-1:0] data_o,
  output logic [CW-1:0] redir_o
);
  fe_cause_e cause;

  always_comb begin
    if (itlb_miss_i)        cause = FE_ADDR;
    else if (icache_miss_i) cause = FE_DATA;
    else if (redirect_i)    cause = FE_REDIR;
    else                    cause = FE_NONE;
  end

  always_comb begin
    lat_o   = dec_bytes_i ? '0 : fe_bound_i;
    bw_o    = dec_bytes_i ? fe_bound_i : '0;
    addr_o  = (cause == FE_ADDR)  ? lat_o : '0;
    data_o  = (cause == FE_DATA)  ? lat_o : '0;
    redir_o = (cause == FE_REDIR) ? lat_o : '0;
  end
endmodule

// File: rtl/tma_be_tree.sv
module tma_be_tree
  import tma_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int CW    = $clog2(SLOTS + 1)
) (
  input  logic [CW-1:0] be_bound_i,
  input  logic          dtlb_miss_i,
  input  logic          dcache_miss_i,
  input  logic          page_walk_i,
  input  logic          serialize_i,
  output logic [CW-1:0] mem_o,
  output logic [CW-1:0] core_o,
  output logic [CW-1:0] maddr_o,
  output logic [CW-1:0] mdata_o,
  output logic [CW-1:0] serial_o
);
  mem_cause_e cause;
  logic       mem_stall;

  always_comb begin
    mem_stall = dtlb_miss_i | dcache_miss_i | page_walk_i;
    // translation stalls outrank data stalls
    if (dtlb_miss_i || page_walk_i) cause = MEM_ADDR;
    else if (dcache_miss_i)         cause = MEM_DATA;
    else                            cause = MEM_NONE;
  end

  always_comb begin
    mem_o    = mem_stall ? be_bound_i : '0;
    core_o   = mem_stall ? '0 : be_bound_i;
    maddr_o  = (cause == MEM_ADDR) ? mem_o : '0;
    mdata_o  = (cause == MEM_DATA) ? mem_o : '0;
    serial_o = serialize_i ? core_o : '0;
  end
endmodule

// File: rtl/tma_slot_classifier.sv
module tma_slot_classifier #(
  parameter int SLOTS = 4,
  parameter int CW    = $clog2(SLOTS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] fe_offer_i,
  input  logic [CW-1:0] be_accept_i,
  input  logic          dec_bytes_i,
  input  logic          flush_i,
  input  logic          recover_i,
  input  logic [CW-1:0] retired_i,
  input  logic          itlb_miss_i,
  input  logic          icache_miss_i,
  input  logic          redirect_i,
  input  logic          dtlb_miss_i,
  input  logic          dcache_miss_i,
  input  logic          page_walk_i,
  input  logic          serialize_i,
  output logic [CW-1:0] retire_o,
  output logic [CW-1:0] bad_spec_o,
  output logic [CW-1:0] fe_bound_o,
  output logic [CW-1:0] be_bound_o,
  output logic [CW-1:0] fe_lat_o,
  output logic [CW-1:0] fe_bw_o,
  output logic [CW-1:0] mem_bound_o,
  output logic [CW-1:0] core_bound_o,
  output logic [CW-1:0] fe_addr_o,
  output logic [CW-1:0] fe_data_o,
  output logic [CW-1:0] fe_redir_o,
  output logic [CW-1:0] mem_addr_o,
  output logic [CW-1:0] mem_data_o,
  output logic [CW-1:0] core_serial_o
);
  localparam int NCNT = 14;

  logic [CW-1:0] nxt [NCNT];
  logic [CW-1:0] cnt_q [NCNT];

  tma_l1_split #(.SLOTS(SLOTS), .CW(CW)) i_l1 (
    .offer_i   (fe_offer_i),
    .accept_i  (be_accept_i),
    .retired_i (retired_i),
    .flush_i   (flush_i),
    .recover_i (recover_i),
    .retire_o  (nxt[0]),
    .bad_o     (nxt[1]),
    .fe_o      (nxt[2]),
    .be_o      (nxt[3])
  );

  tma_fe_tree #(.SLOTS(SLOTS), .CW(CW)) i_fe (
    .fe_bound_i    (nxt[2]),
    .dec_bytes_i   (dec_bytes_i),
    .itlb_miss_i   (itlb_miss_i),
    .icache_miss_i (icache_miss_i),
    .redirect_i    (redirect_i),
    .lat_o         (nxt[4]),
    .bw_o          (nxt[5]),
    .addr_o        (nxt[8]),
    .data_o        (nxt[9]),
    .redir_o       (nxt[10])
  );

  tma_be_tree #(.SLOTS(SLOTS), .CW(CW)) i_be (
    .be_bound_i    (nxt[3]),
    .dtlb_miss_i   (dtlb_miss_i),
    .dcache_miss_i (dcache_miss_i),
    .page_walk_i   (page_walk_i),
    .serialize_i   (serialize_i),
    .mem_o         (nxt[6]),
    .core_o        (nxt[7]),
    .maddr_o       (nxt[11]),
    .mdata_o       (nxt[12]),
    .serial_o      (nxt[13])
  );

  for (genvar g = 0; g < NCNT; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q[g] <= '0;
      else         cnt_q[g] <= nxt[g];
    end
  end

  assign retire_o      = cnt_q[0];
  assign bad_spec_o    = cnt_q[1];
  assign fe_bound_o    = cnt_q[2];
  assign be_bound_o    = cnt_q[3];
  assign fe_lat_o      = cnt_q[4];
  assign fe_bw_o       = cnt_q[5];
  assign mem_bound_o   = cnt_q[6];
  assign core_bound_o  = cnt_q[7];
  assign fe_addr_o     = cnt_q[8];
  assign fe_data_o     = cnt_q[9];
  assign fe_redir_o    = cnt_q[10];
  assign mem_addr_o    = cnt_q[11];
  assign mem_data_o    = cnt_q[12];
  assign core_serial_o = cnt_q[13];

  assert_l1_sum_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (32'(retire_o) + 32'(bad_spec_o) + 32'(fe_bound_o)
                       + 32'(be_bound_o)) == SLOTS);

  assert_be_track_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> 32'(be_bound_o) ==
      SLOTS - ((32'($past(be_accept_i)) > SLOTS) ? SLOTS : 32'($past(be_accept_i))));

  assert_fe_split_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(fe_lat_o) + 32'(fe_bw_o) == 32'(fe_bound_o));

  assert_fe_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({fe_addr_o != '0, fe_data_o != '0, fe_redir_o != '0}) <= 1
    && 32'(fe_addr_o) + 32'(fe_data_o) + 32'(fe_redir_o) <= 32'(fe_lat_o));

  assert_be_split_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(mem_bound_o) + 32'(core_bound_o) == 32'(be_bound_o));

  assert_mem_prio_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_addr_o != '0 && mem_data_o != '0)
    && 32'(mem_addr_o) + 32'(mem_data_o) <= 32'(mem_bound_o));

  assert_serial_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_serial_o <= core_bound_o);
endmodule

// File: tb/test_tma_slot_classifier.sv
module test_tma_slot_classifier;
  localparam int SLOTS = 4;
  localparam int CW    = $clog2(SLOTS + 1);

  logic clk = 0, rst_ni = 0;
  logic [CW-1:0] offer = 0, accept = 0, retired = 0;
  logic dbytes = 0, flush = 0, recov = 0;
  logic itlb = 0, icm = 0, redir = 0, dtlb = 0, dcm = 0, walk = 0, ser = 0;
  logic [CW-1:0] act [14];
  int exp_v [14];
  int vectors = 0, miscompares = 0;

  always #2.5 clk = ~clk;

  tma_slot_classifier #(.SLOTS(SLOTS)) i_tma_slot_classifier (
    .clk_i(clk), .rst_ni(rst_ni), .fe_offer_i(offer), .be_accept_i(accept),
    .dec_bytes_i(dbytes), .flush_i(flush), .recover_i(recov), .retired_i(retired),
    .itlb_miss_i(itlb), .icache_miss_i(icm), .redirect_i(redir),
    .dtlb_miss_i(dtlb), .dcache_miss_i(dcm), .page_walk_i(walk), .serialize_i(ser),
    .retire_o(act[0]), .bad_spec_o(act[1]), .fe_bound_o(act[2]), .be_bound_o(act[3]),
    .fe_lat_o(act[4]), .fe_bw_o(act[5]), .mem_bound_o(act[6]), .core_bound_o(act[7]),
    .fe_addr_o(act[8]), .fe_data_o(act[9]), .fe_redir_o(act[10]),
    .mem_addr_o(act[11]), .mem_data_o(act[12]), .core_serial_o(act[13]));

  function automatic string tag(int i);
    case (i)
      0: return "R6 retire"; 1: return "R5 bad_spec"; 2: return "R4 fe_bound";
      3: return "R3 be_bound"; 4: return "R7 fe_lat"; 5: return "R7 fe_bw";
      6: return "R9 mem_bound"; 7: return "R9 core_bound"; 8: return "R8 fe_addr";
      9: return "R8 fe_data"; 10: return "R8 fe_redir"; 11: return "R10 mem_addr";
      12: return "R10 mem_data"; default: return "R11 core_serial";
    endcase
  endfunction

  function automatic int clampn(int x);
    return (x > SLOTS) ? SLOTS : x;
  endfunction

  // expected counts from the requirements, using the currently driven inputs
  task automatic model();
    int o, a, r, iss, emp, ret, lat, be;
    o = clampn(int'(offer)); a = clampn(int'(accept)); r = clampn(int'(retired)); // R12
    iss = (o < a) ? o : a;
    emp = a - iss;
    ret = flush ? 0 : ((r < iss) ? r : iss);
    exp_v[0] = ret;
    exp_v[1] = (iss - ret) + (recov ? emp : 0);
    exp_v[2] = recov ? 0 : emp;
    be = SLOTS - a;
    exp_v[3] = be;
    lat = dbytes ? 0 : exp_v[2];
    exp_v[4] = lat;
    exp_v[5] = dbytes ? exp_v[2] : 0;
    exp_v[8]  = itlb ? lat : 0;
    exp_v[9]  = (!itlb && icm) ? lat : 0;
    exp_v[10] = (!itlb && !icm && redir) ? lat : 0;
    exp_v[6]  = (dtlb || dcm || walk) ? be : 0;
    exp_v[7]  = (dtlb || dcm || walk) ? 0 : be;
    exp_v[11] = (dtlb || walk) ? exp_v[6] : 0;
    exp_v[12] = (!dtlb && !walk && dcm) ? exp_v[6] : 0;
    exp_v[13] = ser ? exp_v[7] : 0;
  endtask

  // drive at negedge, result due after the next posedge; sample at following negedge
  task automatic apply(int o, int a, int r, bit fl, bit rc, bit db,
                       bit it, bit ic, bit rd, bit dt, bit dc, bit pw, bit sr);
    int sum;
    offer = CW'(o); accept = CW'(a); retired = CW'(r);
    flush = fl; recov = rc; dbytes = db;
    itlb = it; icm = ic; redir = rd; dtlb = dt; dcm = dc; walk = pw; ser = sr;
    model();
    @(negedge clk);
    vectors++;
    sum = 0;
    for (int i = 0; i < 14; i++) begin
      if (int'(act[i]) != exp_v[i]) begin
        miscompares++;
        $display("FAIL %s: got %0d expected %0d", tag(i), act[i], exp_v[i]);
      end
    end
    for (int i = 0; i < 4; i++) sum += int'(act[i]);
    vectors++;
    if (sum != SLOTS) begin
      miscompares++;
      $display("FAIL R2 level-1 sum: got %0d expected %0d", sum, SLOTS);
    end
  endtask

  initial begin
    #200000;
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    vectors++;
    for (int i = 0; i < 14; i++)
      if (act[i] != '0) begin
        miscompares++;
        $display("FAIL R1 %s: got %0d expected 0", tag(i), act[i]);
      end
    rst_ni = 1;
    @(negedge clk);
    // directed corners
    apply(4, 4, 4, 0, 0, 0, 0,0,0,0,0,0,0);  // R6 full retire
    apply(4, 4, 2, 0, 0, 0, 0,0,0,0,0,0,0);  // R6 partial retire
    apply(3, 4, 3, 1, 0, 0, 0,0,0,0,0,0,0);  // R5 flush drops all
    apply(0, 4, 0, 0, 1, 0, 1,0,0,0,0,0,0);  // R4 recovery bubbles
    apply(1, 4, 1, 0, 0, 0, 1,1,1,0,0,0,0);  // R8 addr beats data, redirect
    apply(1, 4, 1, 0, 0, 0, 0,1,1,0,0,0,0);  // R8 data beats redirect
    apply(1, 4, 1, 0, 0, 0, 0,0,1,0,0,0,0);  // R8 redirect
    apply(1, 4, 1, 0, 0, 0, 0,0,0,0,0,0,0);  // R8 no cause
    apply(2, 4, 2, 0, 0, 1, 1,1,1,0,0,0,0);  // R7 bandwidth
    apply(4, 1, 1, 0, 0, 0, 0,0,0,0,1,1,0);  // R10 walk beats data
    apply(4, 0, 0, 0, 0, 0, 0,0,0,0,1,0,1);  // R10 data only
    apply(4, 2, 2, 0, 0, 0, 0,0,0,0,0,0,1);  // R11 serialization
    apply(4, 2, 2, 0, 0, 0, 0,0,0,0,0,0,0);  // R9 core, no serial
    apply(7, 6, 5, 0, 0, 0, 0,0,0,0,0,0,0);  // R12 clamp above SLOTS
    apply(0, 7, 7, 0, 0, 0, 0,0,0,0,0,0,0);  // R12 clamp accept
    for (int k = 0; k < 2000; k++) begin
      apply($urandom % 8, $urandom % 8, $urandom % 8,
            ($urandom % 8) == 0, ($urandom % 4) == 0, $urandom % 2,
            $urandom % 2, $urandom % 2, $urandom % 2,
            $urandom % 2, $urandom % 2, ($urandom % 4) == 0, $urandom % 2);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule